// File: doc/BRIEF.md
# Two-Button Stopwatch Counter with Split Display

This block is the timekeeping core of a stopwatch. It is clocked by the system clock and advances on a one-cycle 1 ms enable. It keeps a cascaded BCD count of minutes, seconds and hundredths up to 59:59.99, with an undisplayed millisecond decade beneath the hundredths. Two single-cycle key pulses, already debounced, control it. Start/Stop starts, pauses and resumes the count. Split/Reset freezes the display while the count keeps running, and zeroes the count when the watch is paused.

A four-state controller emits a three-bit code. Each bit of the code directly drives one function: synchronous clear, count enable, and a transparent display hold. The six displayed digits pass through a hold stage. That stage tracks the live count while its enable bit is set and keeps its last value while the bit is clear. The clock divider, key debouncing, display scanning and segment decoding sit outside the block.

Top module: `stopwatch_core`

## Requirements
- R1: `state_o` is one of four codes: 3'b111 cleared, 3'b011 running, 3'b001 paused, 3'b010 split. After reset the state is cleared and every digit reads zero.
- R2: From cleared, a Start/Stop pulse goes to running. From running, Start/Stop goes to paused and Split/Reset goes to split.
- R3: From split, Split/Reset returns to running. From paused, Start/Stop returns to running and Split/Reset returns to cleared.
- R4: A key pulse with no listed transition leaves the state unchanged. Start/Stop in split and Split/Reset in cleared are examples. Two pulses in the same cycle are both ignored.
- R5: In running and split, each cycle with `tick_i` high advances the count by one millisecond. Cycles without a tick, and the other states, do not advance it.
- R6: `digits_o` holds six 4-bit BCD fields. Bits [3:0] are hundredths, [7:4] tenths, [11:8] seconds units, [15:12] seconds tens, [19:16] minutes units and [23:20] minutes tens. A digit advances only when every lower digit, including the hidden millisecond digit, is at its maximum. Seconds tens and minutes tens roll over at SEC_TENS_MOD and MIN_TENS_MOD (default 6). The other digits roll over at 10, and the hidden millisecond digit rolls over at MS_MOD. After the maximum count the whole count wraps to zero and keeps counting.
- R7: While the state is cleared, the count is held at zero. One cycle after entering cleared, `digits_o` reads all zeros.
- R8: In split, `digits_o` keeps the count from just before the edge that entered split while counting continues. Back in running, the display shows the live count again.
- R9: While paused, the count and the display stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms count enable, one cycle wide |
| start_stop_i | input | 1 | Start/Stop key pulse, one cycle wide |
| split_reset_i | input | 1 | Split/Reset key pulse, one cycle wide |
| digits_o | output | 24 | Displayed BCD digits, hundredths in the low nibble |
| state_o | output | 3 | Controller code {clear, count enable, display track} |

## Verification
The bench builds the block with MS_MOD=1, SEC_TENS_MOD=6 and MIN_TENS_MOD=1. This shortens the full range to 60,000 ticks, so the wrap back to zero after the top count falls inside the run. The mod-6 seconds-tens rollover, and every carry between the decade digits, are still exercised. The bench drives a tick on most cycles and a sparse tick in one phase. Key pulses arrive in every state, including illegal and simultaneous ones, so that every transition and every frozen-display window is compared.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned DIGIT_W     = 4;
  localparam int unsigned NUM_DIGITS  = 7;               // hidden ms digit + six shown
  localparam int unsigned DISP_DIGITS = NUM_DIGITS - 1;
  localparam int unsigned DISP_W      = DISP_DIGITS * DIGIT_W;

  // bit2 = clear, bit1 = count enable, bit0 = display tracks live count
  typedef enum logic [2:0] {
    ST_CLEAR = 3'b111,
    ST_RUN   = 3'b011,
    ST_PAUSE = 3'b001,
    ST_SPLIT = 3'b010
  } sw_state_e;

  function automatic int unsigned digit_mod(int unsigned idx, int unsigned ms_mod,
                                            int unsigned st_mod, int unsigned mt_mod);
    case (idx)
      0:       return ms_mod;
      4:       return st_mod;
      6:       return mt_mod;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_stop_i,
  input  logic      split_reset_i,
  output sw_state_e state_o
);
  sw_state_e state_q, state_d;
  logic      ss, sr;

  // simultaneous pulses cancel
  assign ss = start_stop_i & ~split_reset_i;
  assign sr = split_reset_i & ~start_stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CLEAR: if (ss) state_d = ST_RUN;
      ST_RUN: begin
        if (ss)      state_d = ST_PAUSE;
        else if (sr) state_d = ST_SPLIT;
      end
      ST_SPLIT: if (sr) state_d = ST_RUN;
      ST_PAUSE: begin
        if (ss)      state_d = ST_RUN;
        else if (sr) state_d = ST_CLEAR;
      end
      default: state_d = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CLEAR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned MOD = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  output logic [DIGIT_W-1:0] val_o
);
  localparam logic [DIGIT_W-1:0] MAX_V = DIGIT_W'(MOD - 1);

  logic [DIGIT_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (clr_i) val_q <= '0;
    else if (inc_i) val_q <= (val_q == MAX_V) ? '0 : val_q + 1'b1;
  end

  assign val_o = val_q;
endmodule

// File: rtl/sw_counter.sv
module sw_counter
  import sw_pkg::*;
#(
  parameter int unsigned MS_MOD       = 10,
  parameter int unsigned SEC_TENS_MOD = 6,
  parameter int unsigned MIN_TENS_MOD = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  output logic [DISP_W-1:0] live_o
);
  logic [DIGIT_W-1:0] val [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] carry;

  assign carry[0] = en_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    localparam int unsigned M = digit_mod(i, MS_MOD, SEC_TENS_MOD, MIN_TENS_MOD);
    sw_digit #(.MOD(M)) u_digit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (carry[i]),
      .val_o (val[i])
    );
    if (i < NUM_DIGITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] && (val[i] == DIGIT_W'(M - 1));
    end
    if (i > 0) begin : g_out
      assign live_o[(i-1)*DIGIT_W +: DIGIT_W] = val[i];
    end
  end
endmodule

// File: rtl/sw_hold.sv
module sw_hold
  import sw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              track_i,
  input  logic [DISP_W-1:0] live_i,
  output logic [DISP_W-1:0] disp_o
);
  logic [DISP_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (track_i) hold_q <= live_i;
  end

  // transparent while tracking, frozen otherwise
  assign disp_o = track_i ? live_i : hold_q;
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int unsigned MS_MOD       = 10,
  parameter int unsigned SEC_TENS_MOD = 6,
  parameter int unsigned MIN_TENS_MOD = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_stop_i,
  input  logic              split_reset_i,
  output logic [DISP_W-1:0] digits_o,
  output logic [2:0]        state_o
);
  sw_state_e         state;
  logic [DISP_W-1:0] live;

  sw_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_stop_i (start_stop_i),
    .split_reset_i(split_reset_i),
    .state_o      (state)
  );

  sw_counter #(
    .MS_MOD      (MS_MOD),
    .SEC_TENS_MOD(SEC_TENS_MOD),
    .MIN_TENS_MOD(MIN_TENS_MOD)
  ) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state[2]),
    .en_i  (state[1] & tick_i),
    .live_o(live)
  );

  sw_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .track_i(state[0]),
    .live_i (live),
    .disp_o (digits_o)
  );

  assign state_o = state;
endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import sw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_stop_i,
  input logic              split_reset_i,
  input logic [DISP_W-1:0] digits_o,
  input logic [2:0]        state_o
);
  a_r1_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o inside {ST_CLEAR, ST_RUN, ST_PAUSE, ST_SPLIT});

  a_r4_both_keys_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_stop_i && split_reset_i) |=> $stable(state_o));

  a_r3_clear_only_from_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_CLEAR && state_o != ST_PAUSE) |=> (state_o != ST_CLEAR));

  a_r7_cleared_digits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CLEAR) |=> (state_o != ST_CLEAR || digits_o == '0));

  a_r8_split_display_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SPLIT) |=> (state_o != ST_SPLIT || $stable(digits_o)));

  a_r9_pause_display_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PAUSE) |=> (state_o != ST_PAUSE || $stable(digits_o)));
endmodule

bind stopwatch_core sw_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_stop_i (start_stop_i),
  .split_reset_i(split_reset_i),
  .digits_o     (digits_o),
  .state_o      (state_o)
);

// File: tb/stopwatch_core_tb.sv
`timescale 1ns/1ps
module stopwatch_core_tb;
  localparam int MS_MOD = 1;
  localparam int ST_MOD = 6;
  localparam int MT_MOD = 1;
  localparam int MODS [7] = '{MS_MOD, 10, 10, 10, ST_MOD, 10, MT_MOD};
  localparam int TOTAL = MS_MOD * 1000 * ST_MOD * 10 * MT_MOD;

  logic clk = 0, rst_n = 0, tick = 0, ss = 0, sr = 0;
  logic [23:0] digits;
  logic [2:0]  state;

  int errors = 0, checks = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  int m_state = 3'b111, m_cnt = 0, m_hold = 0;

  always #2.5 clk = ~clk;

  stopwatch_core #(.MS_MOD(MS_MOD), .SEC_TENS_MOD(ST_MOD), .MIN_TENS_MOD(MT_MOD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_stop_i(ss),
    .split_reset_i(sr), .digits_o(digits), .state_o(state));

  function automatic logic [23:0] to_disp(int cnt);
    logic [23:0] r = '0;
    int c = cnt;
    for (int i = 0; i < 7; i++) begin
      if (i > 0) r[(i-1)*4 +: 4] = 4'(c % MODS[i]);
      c = c / MODS[i];
    end
    return r;
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 3'b111; m_cnt = 0; m_hold = 0;
    end else begin
      bit s1, s2;
      s1 = ss && !sr; s2 = sr && !ss;
      if (m_state[0]) m_hold = m_cnt;
      if (m_state[2]) m_cnt = 0;
      else if (m_state[1] && tick) m_cnt = (m_cnt + 1) % TOTAL;
      case (m_state)
        3'b111: if (s1) m_state = 3'b011;
        3'b011: if (s1) m_state = 3'b001; else if (s2) m_state = 3'b010;
        3'b010: if (s2) m_state = 3'b011;
        3'b001: if (s1) m_state = 3'b011; else if (s2) m_state = 3'b111;
        default: ;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [23:0] exp_d;
      exp_d = m_state[0] ? to_disp(m_cnt) : to_disp(m_hold);
      checks += 2;
      if (state !== 3'(m_state)) begin
        errors++;
        $display("FAIL %s state: actual=%b expected=%b at t=%0t", req, state, 3'(m_state), $time);
      end
      if (digits !== exp_d) begin
        errors++;
        $display("FAIL %s digits: actual=%h expected=%h at t=%0t", req, digits, exp_d, $time);
      end
    end
  end

  task automatic idle(int n, int tick_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ss = 0; sr = 0;
      tick = (tick_every > 0) && (i % tick_every == 0);
    end
  endtask

  task automatic press(bit a, bit b);
    @(negedge clk);
    ss = a; sr = b; tick = 1;
    @(negedge clk);
    ss = 0; sr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; idle(5, 1);
    req = "R7"; idle(20, 1);               // ticks while cleared: stays zero
    req = "R4"; press(0, 1); idle(5, 1);   // split in cleared: ignored
    req = "R2"; press(1, 0);
    req = "R5"; idle(1500, 1);
    req = "R6"; idle(1200, 1);             // crosses seconds boundaries
    req = "R4"; press(1, 1); idle(10, 1);  // both keys: ignored
    req = "R2"; press(0, 1);
    req = "R8"; idle(300, 1);
    req = "R4"; press(1, 0); idle(20, 1);  // start in split: ignored
    req = "R3"; press(0, 1);
    req = "R8"; idle(30, 1);
    req = "R5"; idle(200, 3);              // sparse ticks
    idle(50, 0);                           // no ticks
    req = "R2"; press(1, 0);
    req = "R9"; idle(100, 1);
    req = "R3"; press(1, 0); idle(50, 1);
    req = "R2"; press(1, 0); idle(10, 1);
    req = "R3"; press(0, 1);
    req = "R7"; idle(20, 1);
    req = "R2"; press(1, 0);
    req = "R6"; idle(TOTAL + 1000, 1);     // full-range wrap to zero
    finish_run();
  end
endmodule